// File: doc/BRIEF.md
# Parallel Flash Bus Front-End

This block sits between the asynchronous pins of a parallel flash device and its synchronous internals. It samples the active-low chip select, output strobe and write strobe, together with the address and write-data buses, on a fast internal clock. From the sampled strobes it classifies every cycle as standby, read, output-disabled or write. The strobe classification has a fixed latency.

During a read it presents the sampled address to the storage array. On the following clock it registers the returned byte and raises the data-bus drive enable. Real tri-state pads are outside the block, so that enable stands in for them.

During a write it follows the two strobes independently, so either one can control the cycle. The address is taken when the second of the two strobes goes low. The data is taken from the last sample before the first of them goes high. Each completed write is then handed to the command controller as one single-cycle event that carries the captured address and data. A busy indication from the controller holds the drive enable off.

Top module: `flash_bus_front`

## Requirements
- R1: The strobes, address and data pass through a two-flop synchroniser before any decision. A change on the strobes reaches `mode_o` and `dout_oe_o` on the third rising clock edge after it, and not earlier.
- R2: With chip select low, output strobe low, write strobe high and `busy_i` low, `dout_oe_o` is 1 and `dout_o` equals `array_rdata_i` for the address presented on `rd_addr_o`.
- R3: Whenever chip select or output strobe is high, `dout_oe_o` is 0 and `dout_o` is all zeros.
- R4: With chip select high the block is in standby (`mode_o` = 0) and issues no write event, whatever the other strobes do.
- R5: `mode_o` encodes the sampled strobes as follows:
  - 0: chip select high (standby).
  - 1: chip select low, output strobe low, write strobe high (read).
  - 2: chip select low with output strobe and write strobe both high, or all three strobes low (output disabled).
  - 3: chip select low, output strobe high, write strobe low (write).
- R6: The write address is the address sampled in the cycle when the later of the two falling edges of chip select and write strobe is seen. Later address changes have no effect on it.
- R7: The write data is the data sampled in the last cycle with both chip select and write strobe low, before the earlier of their two rising edges. Data changes from that rising edge on have no effect on it.
- R8: Each completed write cycle produces exactly one `wr_valid_o` pulse, one clock long, with `wr_addr_o` and `wr_data_o` valid in the same cycle.
- R9: While `busy_i` is high, `dout_oe_o` is 0 and `dout_o` is zero in the next cycle, even when the read combination is present.
- R10: If the output strobe is low when both chip select and write strobe become low, that strobe cycle produces no write event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip select, active low, asynchronous |
| oe_n | input | 1 | Output strobe, active low, asynchronous |
| we_n | input | 1 | Write strobe, active low, asynchronous |
| addr_i | input | AW | Address pins |
| data_i | input | DW | Write data pins |
| busy_i | input | 1 | Controller busy, holds the drive enable off |
| array_rdata_i | input | DW | Byte returned by the array for `rd_addr_o` |
| rd_addr_o | output | AW | Synchronised address presented to the array |
| dout_o | output | DW | Read data toward the pads |
| dout_oe_o | output | 1 | Pad drive enable (stands in for tri-state) |
| mode_o | output | 2 | Current bus mode, encoded as in R5 |
| wr_valid_o | output | 1 | Single-cycle write event |
| wr_addr_o | output | AW | Address of the write event |
| wr_data_o | output | DW | Data of the write event |

## Verification
The assertions check, on every cycle, these properties:
- a write event never lasts two cycles;
- the captured address stays frozen while a write cycle is open;
- no event appears across two standby cycles;
- the drive enable is never on after a busy cycle;
- the data bus is zero whenever the drive enable is off.

Only the bench scenarios can show the rest:
- that the address comes from the later falling edge and the data from the earlier rising edge, under both strobe orderings;
- the three-edge latency of the synchroniser;
- that a cycle opened with the output strobe low is discarded;
- that the mode table matches every strobe combination.

// File: rtl/fbf_pkg.sv
package fbf_pkg;
    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_READ    = 2'd1,
        MODE_OUTOFF  = 2'd2,
        MODE_WRITE   = 2'd3
    } bus_mode_e;
endpackage

// File: rtl/fbf_sync.sv
module fbf_sync #(
    parameter int              W       = 8,
    parameter int              STAGES  = 2,
    parameter logic [W-1:0]    RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_comb stage_d[g] = in_i;
        end else begin : g_next
            always_comb stage_d[g] = stage_q[g-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stage_q[g] <= RST_VAL;
            else        stage_q[g] <= stage_d[g];
        end
    end

    assign out_o = stage_q[STAGES-1];
endmodule

// File: rtl/fbf_read_path.sv
module fbf_read_path
    import fbf_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_s,
    input  logic            oe_s,
    input  logic            we_s,
    input  logic            busy_i,
    input  logic [DW-1:0]   rdata_i,
    output bus_mode_e       mode_o,
    output logic [DW-1:0]   dout_o,
    output logic            dout_oe_o
);
    typedef struct packed {
        bus_mode_e       mode;
        logic            drive;
        logic [DW-1:0]   data;
    } rd_state_t;

    rd_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ce_s)               st_d.mode = MODE_STANDBY;
        else if (!oe_s && we_s) st_d.mode = MODE_READ;
        else if (oe_s && !we_s) st_d.mode = MODE_WRITE;
        else                    st_d.mode = MODE_OUTOFF;
        st_d.drive = (st_d.mode == MODE_READ) && !busy_i;
        st_d.data  = st_d.drive ? rdata_i : '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{mode: MODE_STANDBY, drive: 1'b0, data: '0};
        else        st_q <= st_d;
    end

    assign mode_o    = st_q.mode;
    assign dout_o    = st_q.data;
    assign dout_oe_o = st_q.drive;

    // R3
    quiet_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_oe_o |-> (dout_o == '0));

    // R9
    busy_blocks_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(busy_i) |-> !dout_oe_o);
endmodule

// File: rtl/fbf_write_capture.sv
module fbf_write_capture #(
    parameter int AW = 17,
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_s,
    input  logic            oe_s,
    input  logic            we_s,
    input  logic [AW-1:0]   addr_s,
    input  logic [DW-1:0]   data_s,
    output logic            wr_valid_o,
    output logic [AW-1:0]   wr_addr_o,
    output logic [DW-1:0]   wr_data_o
);
    typedef struct packed {
        logic            both_low;
        logic            open;
        logic [AW-1:0]   addr_lat;
        logic [DW-1:0]   data_hold;
        logic            valid;
        logic [AW-1:0]   ev_addr;
        logic [DW-1:0]   ev_data;
    } wc_state_t;

    wc_state_t st_d, st_q;
    logic both_low_now, starts, ends;

    always_comb begin
        both_low_now = !ce_s && !we_s;
        starts       = both_low_now && !st_q.both_low;
        ends         = !both_low_now && st_q.both_low;

        st_d          = st_q;
        st_d.both_low = both_low_now;
        st_d.valid    = 1'b0;

        if (starts && oe_s) begin
            st_d.open     = 1'b1;
            st_d.addr_lat = addr_s;
        end
        if (both_low_now) begin
            st_d.data_hold = data_s;
        end
        if (ends) begin
            st_d.open = 1'b0;
            if (st_q.open) begin
                st_d.valid   = 1'b1;
                st_d.ev_addr = st_q.addr_lat;
                st_d.ev_data = st_q.data_hold;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign wr_valid_o = st_q.valid;
    assign wr_addr_o  = st_q.ev_addr;
    assign wr_data_o  = st_q.ev_data;

    // R8
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid_o |=> !wr_valid_o);

    // R6
    addr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.open && $past(st_q.open)) |-> $stable(st_q.addr_lat));
endmodule

// File: rtl/flash_bus_front.sv
module flash_bus_front
    import fbf_pkg::*;
#(
    parameter int AW          = 17,
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ce_n,
    input  logic            oe_n,
    input  logic            we_n,
    input  logic [AW-1:0]   addr_i,
    input  logic [DW-1:0]   data_i,
    input  logic            busy_i,
    input  logic [DW-1:0]   array_rdata_i,
    output logic [AW-1:0]   rd_addr_o,
    output logic [DW-1:0]   dout_o,
    output logic            dout_oe_o,
    output logic [1:0]      mode_o,
    output logic            wr_valid_o,
    output logic [AW-1:0]   wr_addr_o,
    output logic [DW-1:0]   wr_data_o
);
    localparam int SW = 3 + AW + DW;
    localparam logic [SW-1:0] SYNC_IDLE = {3'b111, {(AW+DW){1'b0}}};

    logic [SW-1:0]  raw_vec, sync_vec;
    logic           ce_s, oe_s, we_s;
    logic [AW-1:0]  addr_s;
    logic [DW-1:0]  data_s;
    bus_mode_e      mode;

    assign raw_vec = {ce_n, oe_n, we_n, addr_i, data_i};

    fbf_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_IDLE)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .in_i  (raw_vec),
        .out_o (sync_vec)
    );

    assign {ce_s, oe_s, we_s, addr_s, data_s} = sync_vec;
    assign rd_addr_o = addr_s;

    fbf_read_path #(.DW(DW)) u_read (
        .clk       (clk),
        .rst_n     (rst_n),
        .ce_s      (ce_s),
        .oe_s      (oe_s),
        .we_s      (we_s),
        .busy_i    (busy_i),
        .rdata_i   (array_rdata_i),
        .mode_o    (mode),
        .dout_o    (dout_o),
        .dout_oe_o (dout_oe_o)
    );

    assign mode_o = mode;

    fbf_write_capture #(.AW(AW), .DW(DW)) u_wcap (
        .clk        (clk),
        .rst_n      (rst_n),
        .ce_s       (ce_s),
        .oe_s       (oe_s),
        .we_s       (we_s),
        .addr_s     (addr_s),
        .data_s     (data_s),
        .wr_valid_o (wr_valid_o),
        .wr_addr_o  (wr_addr_o),
        .wr_data_o  (wr_data_o)
    );

    // R4
    standby_no_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == MODE_STANDBY && $past(mode_o) == MODE_STANDBY) |-> !wr_valid_o);

    // R3
    drive_needs_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe_o |-> (mode_o == MODE_READ));
endmodule

// File: tb/flash_bus_front_bench.sv
module flash_bus_front_bench;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 8;
    localparam int DW = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] data = '0;
    logic busy = 1'b0;
    logic [DW-1:0] array_rdata;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] dout;
    logic dout_oe;
    logic [1:0] mode;
    logic wr_valid;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int tests = 0, fails = 0;
    int pulses = 0;
    logic [AW-1:0] last_addr;
    logic [DW-1:0] last_data;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign array_rdata = rd_addr ^ 8'hA5;

    flash_bus_front #(.AW(AW), .DW(DW)) u_flash_bus_front (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr_i(addr), .data_i(data), .busy_i(busy), .array_rdata_i(array_rdata),
        .rd_addr_o(rd_addr), .dout_o(dout), .dout_oe_o(dout_oe), .mode_o(mode),
        .wr_valid_o(wr_valid), .wr_addr_o(wr_addr), .wr_data_o(wr_data)
    );

    always @(negedge clk) if (wr_valid) begin
        pulses++;
        last_addr = wr_addr;
        last_data = wr_data;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic int exp_mode(input bit c, input bit o, input bit w);
        if (c) return 0;
        if (!o && w) return 1;
        if (o && !w) return 3;
        return 2;
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        wait_n(3);
        check(mode == 2'd0 && !dout_oe && !wr_valid && dout == '0, "R5 reset", mode, 0);
        rst_n = 1'b1;
        wait_n(3);

        // R1: latency of the strobe path
        addr = 8'h3C;
        wait_n(4);
        ce_n = 1'b0; oe_n = 1'b0;
        wait_n(2);
        check(!dout_oe, "R1 early", dout_oe, 0);
        wait_n(1);
        check(dout_oe && mode == 2'd1, "R1 third edge", {mode, dout_oe}, 3);
        ce_n = 1'b1; oe_n = 1'b1;
        wait_n(5);

        // R2 R3 R5 R9: sweep of all strobe combinations with busy on and off
        for (int b = 0; b < 2; b++) begin
            for (int k = 0; k < 8; k++) begin
                logic [AW-1:0] a;
                bit c, o, w, drv;
                a = 8'(k * 17 + b * 5 + 1);
                c = k[2]; o = k[1]; w = k[0];
                busy = b[0]; addr = a;
                ce_n = c; oe_n = o; we_n = w;
                wait_n(5);
                drv = (exp_mode(c, o, w) == 1) && !b[0];
                check(int'(mode) == exp_mode(c, o, w), "R5 mode", mode, exp_mode(c, o, w));
                check(dout_oe == drv, b ? "R9 busy enable" : "R3 enable", dout_oe, drv);
                check(dout == (drv ? (a ^ 8'hA5) : 8'h00), drv ? "R2 data" : "R3 data",
                      dout, drv ? (a ^ 8'hA5) : 0);
                ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
                wait_n(5);
            end
        end
        busy = 1'b0;

        // R4: standby ignores strobe activity
        begin
            int p0;
            p0 = pulses;
            for (int k = 0; k < 6; k++) begin
                oe_n = k[0]; we_n = k[1]; data = 8'(k);
                wait_n(4);
                check(mode == 2'd0 && !dout_oe, "R4 standby", mode, 0);
            end
            oe_n = 1'b1; we_n = 1'b1;
            wait_n(5);
            check(pulses == p0, "R4 no event", pulses - p0, 0);
        end

        // R6 R7 R8: writes under every strobe ordering
        for (int i = 0; i < 16; i++) begin
            logic [AW-1:0] a0, a1;
            logic [DW-1:0] d1, d2;
            int p0;
            a0 = 8'(i * 13); a1 = 8'(i * 29 + 7);
            d1 = 8'(i * 37 + 1); d2 = ~d1;
            p0 = pulses;
            addr = a0; data = d1;
            wait_n(3);
            if (!i[0]) begin
                ce_n = 1'b0; wait_n(3); we_n = 1'b0; addr = a1;
            end else begin
                we_n = 1'b0; wait_n(3); ce_n = 1'b0; addr = a1;
            end
            wait_n(4);
            addr = a0;
            wait_n(2);
            if (!i[1]) begin
                we_n = 1'b1; data = d2; wait_n(3); ce_n = 1'b1;
            end else begin
                ce_n = 1'b1; data = d2; wait_n(3); we_n = 1'b1;
            end
            wait_n(6);
            check(pulses == p0 + 1, "R8 one event", pulses - p0, 1);
            check(last_addr == a1, "R6 address", last_addr, a1);
            check(last_data == d1, "R7 data", last_data, d1);
        end

        // R10: cycle opened with output strobe low is discarded
        begin
            int p0;
            p0 = pulses;
            oe_n = 1'b0; ce_n = 1'b0; we_n = 1'b0;
            wait_n(4);
            oe_n = 1'b1;
            wait_n(3);
            we_n = 1'b1; ce_n = 1'b1;
            wait_n(6);
            check(pulses == p0, "R10 no event", pulses - p0, 0);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule